// File: doc/BRIEF.md
# SD Card Clock Divider with Gated Start and Stop

This block derives the clock that drives an SD or MMC card from the block's own clock. The division is always a power of two. A 16-bit rate register sets the division. Its low field holds a one-hot code, one bit sets the top rate, and another bit enables the clock. A second 16-bit register, the gate register, also carries an enable bit. The card clock runs only while the enable bits in both registers are set. Software stops the clock by clearing the gate enable and then the rate enable. It starts the clock again by setting the rate enable and then the gate enable. A 1-bit mode register is provided for software to hold the inverse of the top-rate bit. It has no effect on the clock.

The block is clocked at twice the host reference rate. The top rate is therefore the reference rate itself, which is the block clock divided by 2. The slowest rate is the reference divided by 512, which is the block clock divided by 1024. Every rate in between is a factor of two from its neighbours. The card clock always stops low and never produces a shortened high pulse. A new rate takes effect only at a falling edge of the card clock. A status output shows whether the card clock is active.

Software reaches the registers through a simple synchronous port. A write takes effect at the clock edge where `wr_en` is high. A read returns data one edge after `rd_en`.

Top module: `sdclk_div_top`

## Requirements
- R1: After reset, `card_clk` and `clk_running` are low, the rate register and the gate register read 0x0000, and the mode register reads 1.
- R2: `card_clk` toggles only while bit 8 of the rate register and bit 8 of the gate register are both set. A register write first acts on the clock in the cycle after the write edge. With either bit clear, the clock is held low once any high phase in progress has ended.
- R3: Bit 15 of the rate register set gives a card clock period of 2 block clock cycles, whatever the value of bits 7:0.
- R4: With bit 15 clear and bits 7:0 all zero, the card clock period is 4 cycles.
- R5: With bit 15 clear and only bit k (k = 0..7) of bits 7:0 set, the card clock period is 2^(k+3) cycles, from 8 up to 1024.
- R6: When more than one of bits 7:0 is set, the lowest-numbered set bit decides the rate.
- R7: When the clock is stopped during a high phase, that high phase still lasts its full half period. After it, `card_clk` stays low.
- R8: A change of rate takes effect at the next falling edge of `card_clk`. The high phase in progress keeps its old length. While the clock is idle and low, a change takes effect at once.
- R9: `clk_running` is high when both enable bits are set or while `card_clk` is high. Otherwise it is low.
- R10: Address 0 is the rate register, address 1 the gate register, address 2 the mode register (bit 0 only, the upper bits read 0), and address 3 reads 0. `rdata` loads at the edge where `rd_en` is high and holds otherwise. The mode register does not change the card clock.
- R11: Writing 0x0000 to the rate register stops the card clock, low, and it stays low.
- R12: When the clock starts from idle, the first rising edge follows a full low half period. The low phase lasts half the period, counted from the first cycle in which both enables are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the host reference rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select for reads and writes |
| wdata | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe |
| rdata | output | 16 | Read data, valid after the edge where `rd_en` is high |
| card_clk | output | 1 | Clock to the card |
| clk_running | output | 1 | Card clock active |

## Verification
The assertions take two things for granted. First, the enables reach the divider only through registered values. Second, the active half-period exponent is reloaded only at a falling edge or while the clock is idle. This is why they can demand a full-length high phase on every fall. The bench writes registers only through the port, one write per call, and lets every setting run for at least three card clock periods before it measures. It measures a period only from the second rising edge after a change, so no mixed old-and-new period is ever measured. It stops and changes rates mid-phase only at points it has located from the sampled card clock.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
    localparam int REG_W   = 16;
    localparam int ADDR_W  = 2;
    localparam int ENA_BIT = 8;
    localparam int TOP_BIT = 15;

    typedef enum logic [ADDR_W-1:0] {
        SEL_RATE = 2'd0,
        SEL_GATE = 2'd1,
        SEL_MODE = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/sdclk_regs.sv
module sdclk_regs
    import sdclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              rd_en,
    output logic [REG_W-1:0]  rdata,
    output logic [REG_W-1:0]  rate_q,
    output logic [REG_W-1:0]  gate_q
);
    typedef struct packed {
        logic [REG_W-1:0] rate;
        logic [REG_W-1:0] gate;
        logic             mode;
        logic [REG_W-1:0] rdata;
    } regs_t;

    regs_t s_d, s_q;
    logic [REG_W-1:0] sel_val;

    always_comb begin
        case (reg_sel_e'(addr))
            SEL_RATE: sel_val = s_q.rate;
            SEL_GATE: sel_val = s_q.gate;
            SEL_MODE: sel_val = {{(REG_W-1){1'b0}}, s_q.mode};
            default:  sel_val = '0;
        endcase

        s_d = s_q;
        if (rd_en) s_d.rdata = sel_val;
        if (wr_en) begin
            case (reg_sel_e'(addr))
                SEL_RATE: s_d.rate = wdata;
                SEL_GATE: s_d.gate = wdata;
                SEL_MODE: s_d.mode = wdata[0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.rate  <= '0;
            s_q.gate  <= '0;
            s_q.mode  <= 1'b1;
            s_q.rdata <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata  = s_q.rdata;
    assign rate_q = s_q.rate;
    assign gate_q = s_q.gate;
endmodule

// File: rtl/sdclk_rate_dec.sv
module sdclk_rate_dec #(
    parameter int FIELD_W = 8,
    localparam int HEXP_W = $clog2(FIELD_W + 2)
) (
    input  logic [FIELD_W-1:0] field,
    input  logic               top_rate,
    output logic [HEXP_W-1:0]  hexp
);
    // hexp is log2 of the half period in block clock cycles
    always_comb begin
        hexp = HEXP_W'(1);
        for (int k = FIELD_W - 1; k >= 0; k--) begin
            if (field[k]) hexp = HEXP_W'(k + 2);
        end
        if (top_rate) hexp = '0;
    end
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen #(
    parameter int FIELD_W = 8,
    localparam int HEXP_W = $clog2(FIELD_W + 2),
    localparam int CNT_W  = FIELD_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HEXP_W-1:0] hexp_req,
    output logic              card_clk,
    output logic [HEXP_W-1:0] hexp_act
);
    typedef struct packed {
        logic              ck;
        logic [CNT_W-1:0]  cnt;
        logic [HEXP_W-1:0] hexp;
    } gen_t;

    gen_t s_d, s_q;
    logic [CNT_W-1:0] lim;
    logic             half_end;

    always_comb begin
        for (int i = 0; i < CNT_W; i++) lim[i] = (i < int'(s_q.hexp));
        half_end = (s_q.cnt == lim);

        s_d = s_q;
        if (s_q.ck) begin
            if (half_end) begin
                s_d.ck   = 1'b0;
                s_d.cnt  = '0;
                s_d.hexp = hexp_req;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else if (run) begin
            if (half_end) begin
                s_d.ck  = 1'b1;
                s_d.cnt = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else begin
            s_d.cnt  = '0;
            s_d.hexp = hexp_req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ck   <= 1'b0;
            s_q.cnt  <= '0;
            s_q.hexp <= HEXP_W'(1);
        end else begin
            s_q <= s_d;
        end
    end

    assign card_clk = s_q.ck;
    assign hexp_act = s_q.hexp;
endmodule

// File: rtl/sdclk_div_top.sv
module sdclk_div_top
    import sdclk_pkg::*;
#(
    parameter int FIELD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [15:0]       wdata,
    input  logic              rd_en,
    output logic [15:0]       rdata,
    output logic              card_clk,
    output logic              clk_running
);
    localparam int HEXP_W = $clog2(FIELD_W + 2);

    logic [REG_W-1:0]  rate_q;
    logic [REG_W-1:0]  gate_q;
    logic [HEXP_W-1:0] hexp_req;
    logic [HEXP_W-1:0] hexp_w;
    logic              run_w;
    logic              regs_unused;

    sdclk_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .rd_en  (rd_en),
        .rdata  (rdata),
        .rate_q (rate_q),
        .gate_q (gate_q)
    );

    sdclk_rate_dec #(.FIELD_W(FIELD_W)) u_dec (
        .field    (rate_q[FIELD_W-1:0]),
        .top_rate (rate_q[TOP_BIT]),
        .hexp     (hexp_req)
    );

    assign run_w = rate_q[ENA_BIT] & gate_q[ENA_BIT];

    sdclk_gen #(.FIELD_W(FIELD_W)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_w),
        .hexp_req (hexp_req),
        .card_clk (card_clk),
        .hexp_act (hexp_w)
    );

    assign clk_running = card_clk | run_w;
    assign regs_unused = ^{rate_q, gate_q};
endmodule

// File: rtl/sdclk_div_chk.sv
module sdclk_div_chk #(
    parameter int FIELD_W = 8,
    localparam int HEXP_W = $clog2(FIELD_W + 2),
    localparam int LEN_W  = FIELD_W + 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              card_clk,
    input logic              clk_running,
    input logic              run,
    input logic [HEXP_W-1:0] hexp
);
    logic [LEN_W-1:0] hi_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hi_len <= '0;
        else if (card_clk) hi_len <= hi_len + 1'b1;
        else               hi_len <= '0;
    end

    // R2
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!card_clk && !run) |=> !card_clk);

    // R12
    rise_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_clk) |-> $past(run));

    // R8
    rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (card_clk && $past(card_clk)) |-> $stable(hexp));

    // R7
    high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(card_clk) |-> (hi_len == (LEN_W'(1) << $past(hexp))));

    // R9
    run_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        card_clk |-> clk_running);
endmodule

bind sdclk_div_top sdclk_div_chk #(.FIELD_W(FIELD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .card_clk    (card_clk),
    .clk_running (clk_running),
    .run         (run_w),
    .hexp        (hexp_w)
);

// File: tb/sim_sdclk_div_top.sv
`timescale 1ns/1ps
module sim_sdclk_div_top;
    localparam int LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'd0;
    logic        rd_en = 1'b0;
    logic [15:0] rdata;
    logic        card_clk;
    logic        clk_running;

    int cyc = 0;
    int nchk = 0;
    int nfail = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    // behavioural reference state
    int m_rate = 0, m_gate = 0, m_mode = 1, m_rd = 0;
    int m_ck = 0, m_cnt = 0, m_half = 2;

    always #4 clk = ~clk;

    sdclk_div_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rd_en(rd_en), .rdata(rdata), .card_clk(card_clk), .clk_running(clk_running)
    );

    function automatic int req_half(int r);
        if (r[15]) return 1;
        for (int k = 0; k < 8; k++) if (r[k]) return 4 << k;
        return 2;
    endfunction

    function automatic bit m_run();
        return (m_rate[8] == 1'b1) && (m_gate[8] == 1'b1);
    endfunction

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            if (nfail < 20) $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == LIMIT) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected=below %0d", cyc, LIMIT);
            finish_up();
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rate = 0; m_gate = 0; m_mode = 1; m_rd = 0;
            m_ck = 0; m_cnt = 0; m_half = 2;
        end else begin
            if (m_ck == 1) begin
                if (m_cnt == m_half - 1) begin
                    m_ck = 0; m_cnt = 0; m_half = req_half(m_rate);
                end else m_cnt++;
            end else if (m_run()) begin
                if (m_cnt == m_half - 1) begin
                    m_ck = 1; m_cnt = 0;
                end else m_cnt++;
            end else begin
                m_cnt = 0; m_half = req_half(m_rate);
            end
            if (rd_en) begin
                case (addr)
                    2'd0: m_rd = m_rate;
                    2'd1: m_rd = m_gate;
                    2'd2: m_rd = m_mode;
                    default: m_rd = 0;
                endcase
            end
            if (wr_en) begin
                case (addr)
                    2'd0: m_rate = int'(wdata);
                    2'd1: m_gate = int'(wdata);
                    2'd2: m_mode = int'(wdata[0]);
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R2 R5 R7 R8 R12 card_clk vs model", int'(card_clk), m_ck);
            chk("R9 clk_running vs model", int'(clk_running), int'(m_ck == 1 || m_run()));
            chk("R10 rdata vs model", int'(rdata), m_rd);
        end
    end

    task automatic wr(int a, int d);
        @(posedge clk); #2;
        wr_en = 1'b1; addr = 2'(a); wdata = 16'(d);
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic rd(int a, int exp, string tag);
        @(posedge clk); #2;
        rd_en = 1'b1; addr = 2'(a);
        @(posedge clk); #2;
        rd_en = 1'b0;
        chk(tag, int'(rdata), exp);
    endtask

    task automatic wait_rise();
        logic prev;
        @(negedge clk); prev = card_clk;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!prev && card_clk) break;
            prev = card_clk;
        end
    endtask

    task automatic period(output int p);
        int t0;
        wait_rise(); wait_rise();
        t0 = cyc;
        wait_rise();
        p = cyc - t0;
    endtask

    task automatic high_after_write(int a, int d, output int len);
        int t0;
        wait_rise();
        t0 = cyc;
        wr(a, d);
        for (int i = 0; i < 3000; i++) begin
            if (!card_clk) break;
            @(negedge clk);
        end
        len = cyc - t0;
    endtask

    task automatic stay_low(int n, string tag);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (card_clk || clk_running) seen++;
        end
        chk(tag, seen, 0);
    endtask

    initial begin
        int p, len;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);
        chk("R1 card_clk after reset", int'(card_clk), 0);
        chk("R1 clk_running after reset", int'(clk_running), 0);
        rd(0, 0, "R1 rate register reset");
        rd(1, 0, "R1 gate register reset");
        rd(2, 1, "R1 mode register reset");

        // R2: rate enable alone keeps the clock low
        wr(0, 16'h0100);
        stay_low(300, "R2 rate enable without gate");
        // start sequence, default field: divide by 4
        wr(1, 16'h0100);
        period(p); chk("R4 zero field period", p, 4);
        // R3: top rate overrides field
        wr(0, 16'h81A5);
        period(p); chk("R3 top rate period", p, 2);
        // R5: each single field bit
        for (int k = 0; k < 8; k++) begin
            wr(0, 16'h0100 | (1 << k));
            period(p); chk($sformatf("R5 field bit %0d period", k), p, 8 << k);
        end
        // R6: lowest set bit wins
        wr(0, 16'h01A4);
        period(p); chk("R6 lowest set bit period", p, 32);
        // R10: mode has no effect on the clock
        wr(2, 16'hFFFF);
        rd(2, 1, "R10 mode register bit 0 only");
        period(p); chk("R10 mode write leaves period", p, 32);
        wr(2, 0);
        rd(3, 0, "R10 unused address reads zero");
        rd(1, 16'h0100, "R10 gate register readback");
        rd(0, 16'h01A4, "R10 rate register readback");
        addr = 2'd1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R10 rdata holds without rd_en", int'(rdata), 16'h01A4);

        // R8: change during a high phase keeps old high length
        wr(0, 16'h0108);
        period(p); chk("R5 bit3 period before change", p, 64);
        high_after_write(0, 16'h0101, len);
        chk("R8 high phase keeps old length", len, 32);
        period(p); chk("R8 new rate after falling edge", p, 8);

        // R7: stop during a high phase
        wr(0, 16'h0108);
        period(p);
        high_after_write(1, 0, len);
        chk("R7 high phase completes on stop", len, 32);
        stay_low(400, "R7 R9 clock held low after stop");
        wr(0, 16'h0008);
        rd(0, 16'h0008, "R2 stop sequence rate readback");

        // restart, then R11 whole-register zero
        wr(0, 16'h0102);
        wr(1, 16'h0100);
        period(p); chk("R12 restart period", p, 16);
        wr(0, 0);
        repeat (20) @(posedge clk);
        stay_low(600, "R11 zero rate register stops clock");

        // R12: idle rate change applies at once, full first low phase
        wr(0, 16'h0103);
        wr(1, 16'h0100);
        period(p); chk("R12 idle rate change period", p, 8);

        repeat (10) @(posedge clk);
        finish_up();
    end
endmodule